// File: doc/BRIEF.md
# Packed Decimal Ripple Adder

This block adds two unsigned decimal numbers held as packed binary-coded digits, four bits per digit, together with a single carry input. It produces the decimal sum in the same packed form and a decimal carry output. The block is purely combinational: outputs follow the inputs with no clock, no state and no handshake. That suits its use inside a larger datapath stage that registers operands and results around it.

Each digit cell first adds its two digits and the incoming decimal carry in plain binary. This gives a four-bit result and a binary carry. A detector flags raw results of ten or more. When the flag is set, the cell adds six to the four-bit result and drops any carry from that second addition. The same flag is passed on as the decimal carry into the next more significant cell. Cells are chained from digit 0 upward, and the flag of the top cell becomes the block's carry output. A digit code above nine on either operand gives an unspecified result.

Top module: `bcd_ripple_adder`

## Requirements
- R1: Digit i of every packed vector sits in bits [4i+3:4i], with digit 0 least significant. Each digit is an unsigned binary value from 0 to 9.
- R2: When all operand digits are 9 or less, every output digit is 9 or less.
- R3: When all operand digits are valid, carry_out times 10^DIGITS plus the decimal value of sum_bcd equals A + B + carry_in.
- R4: A digit cell passes a carry of 1 exactly when its raw sum (digit a + digit b + incoming carry) is 10 or more. Its output digit is then the raw sum minus ten; otherwise it is the raw sum.
- R5: A carry ripples through every digit whose raw sum without the carry is exactly 9. For example, 0999 + 0001 gives 1000.
- R6: carry_out is the decimal carry of the most significant digit. 9999 + 9999 with carry_in 1 gives sum 9999 and carry_out 1.
- R7: carry_in adds one unit to digit 0. Zero plus zero with carry_in 1 gives 0001.
- R8: Adding zero with carry_in 0 returns operand A unchanged, and carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addend_a | input | 4*DIGITS | First packed decimal operand |
| addend_b | input | 4*DIGITS | Second packed decimal operand |
| carry_in | input | 1 | Decimal carry into digit 0 |
| sum_bcd | output | 4*DIGITS | Packed decimal sum |
| carry_out | output | 1 | Decimal carry out of the top digit |

## Verification
The bench builds two copies of the block. One uses the default four digits; the other uses a single digit. The single-digit copy makes it feasible to apply every valid pair of digits with both carry values, 200 cases in all, so the cell's correction and carry rule is covered completely. The four-digit copy reaches the cases that only a chain can show: carries that ripple through long runs of nines, the largest sum, and a spread of scattered operand pairs checked against arithmetic done in the bench.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DEC_SKIP = 4'd6;
  localparam logic [DIGIT_W:0] DEC_LIMIT = 5'd10;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_bin_nibble.sv
module bcd_bin_nibble
  import bcd_add_pkg::*;
(
  input  digit_t op_a,
  input  digit_t op_b,
  input  logic   cin,
  output digit_t raw_z,
  output logic   raw_co
);
  // first stage: plain binary sum of the two digits and the incoming carry
  assign {raw_co, raw_z} = {1'b0, op_a} + {1'b0, op_b} + {{DIGIT_W{1'b0}}, cin};
endmodule

// File: rtl/bcd_fix_detect.sv
module bcd_fix_detect
  import bcd_add_pkg::*;
(
  input  digit_t raw_z,
  input  logic   raw_co,
  output logic   fix
);
  // raw result of ten or more: binary carry, or 1 in bit 3 with bit 2 or bit 1
  assign fix = raw_co | (raw_z[3] & raw_z[2]) | (raw_z[3] & raw_z[1]);

  always_comb begin
    a_r4_fix_iff_over: assert (fix == ({raw_co, raw_z} >= DEC_LIMIT));
  end
endmodule

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_add_pkg::*;
(
  input  digit_t dig_a,
  input  digit_t dig_b,
  input  logic   dcarry_in,
  output digit_t dig_sum,
  output logic   dcarry_out
);
  digit_t bin_z;
  logic   bin_co;
  logic   need_fix;

  bcd_bin_nibble u_bin (
    .op_a  (dig_a),
    .op_b  (dig_b),
    .cin   (dcarry_in),
    .raw_z (bin_z),
    .raw_co(bin_co)
  );

  bcd_fix_detect u_fix (
    .raw_z (bin_z),
    .raw_co(bin_co),
    .fix   (need_fix)
  );

  // second stage: skip the six unused codes; its own carry is dropped
  assign dig_sum    = bin_z + (need_fix ? DEC_SKIP : '0);
  assign dcarry_out = need_fix;

  logic ops_valid;
  assign ops_valid = (dig_a <= 4'd9) && (dig_b <= 4'd9);

  always_comb begin
    if (ops_valid) begin
      a_r2_digit_in_range: assert (dig_sum <= 4'd9);
      a_r3_digit_weight: assert ((dcarry_out ? DEC_LIMIT : 5'd0) + {1'b0, dig_sum}
                                 == {1'b0, dig_a} + {1'b0, dig_b} + {4'd0, dcarry_in});
    end
  end
endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder
  import bcd_add_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [DIGITS*DIGIT_W-1:0] addend_a,
  input  logic [DIGITS*DIGIT_W-1:0] addend_b,
  input  logic                      carry_in,
  output logic [DIGITS*DIGIT_W-1:0] sum_bcd,
  output logic                      carry_out
);
  localparam int VEC_W = DIGITS * DIGIT_W;

  logic [DIGITS:0] dec_carry;
  assign dec_carry[0] = carry_in;

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
    bcd_digit_cell u_cell (
      .dig_a     (addend_a[gi*DIGIT_W +: DIGIT_W]),
      .dig_b     (addend_b[gi*DIGIT_W +: DIGIT_W]),
      .dcarry_in (dec_carry[gi]),
      .dig_sum   (sum_bcd[gi*DIGIT_W +: DIGIT_W]),
      .dcarry_out(dec_carry[gi+1])
    );
  end

  assign carry_out = dec_carry[DIGITS];

  function automatic logic all_valid(input logic [VEC_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++) begin
      if (v[k*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  always_comb begin
    if (all_valid(addend_a) && addend_b == '0 && !carry_in) begin
      a_r8_zero_identity: assert (sum_bcd == addend_a && !carry_out);
    end
  end
endmodule

// File: tb/bcd_ripple_adder_tb.sv
module bcd_ripple_adder_tb;
  localparam int D4 = 4;
  localparam int W4 = D4 * 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W4-1:0] a4, b4, s4;
  logic          ci4, co4;
  logic [3:0]    a1, b1, s1;
  logic          ci1, co1;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  int cycles = 0;

  bcd_ripple_adder #(.DIGITS(D4)) u_dut (
    .addend_a(a4), .addend_b(b4), .carry_in(ci4), .sum_bcd(s4), .carry_out(co4));
  bcd_ripple_adder #(.DIGITS(1)) u_dut_d1 (
    .addend_a(a1), .addend_b(b1), .carry_in(ci1), .sum_bcd(s1), .carry_out(co1));

  function automatic logic [W4-1:0] to_bcd4(input int v);
    logic [W4-1:0] r;
    int t;
    t = v;
    for (int k = 0; k < D4; k++) begin
      r[k*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply4(input int av, input int bv, input logic c, input string req);
    int tot;
    @(negedge clk);
    a4 = to_bcd4(av); b4 = to_bcd4(bv); ci4 = c;
    #2;
    tot = av + bv + int'(c);
    chk(req, {15'd0, co4, s4}, {15'd0, (tot >= 10000), to_bcd4(tot % 10000)});
  endtask

  task automatic t_idle_zero;  // R1 R8
    apply4(0, 0, 1'b0, "R8 zero inputs");
    apply4(1234, 0, 1'b0, "R8 identity");
    apply4(9876, 0, 1'b0, "R8 identity high");
  endtask

  task automatic t_positions;  // R1: each digit lands in its own nibble
    apply4(1, 2, 1'b0, "R1 digit0");
    apply4(30, 40, 1'b0, "R1 digit1");
    apply4(500, 100, 1'b0, "R1 digit2");
    apply4(7000, 2000, 1'b0, "R1 digit3");
  endtask

  task automatic t_single_digit_all;  // R2 R4 exhaustive on one cell
    for (int x = 0; x < 10; x++)
      for (int y = 0; y < 10; y++)
        for (int c = 0; c < 2; c++) begin
          int raw;
          @(negedge clk);
          a1 = 4'(x); b1 = 4'(y); ci1 = c[0];
          #2;
          raw = x + y + c;
          chk("R4 digit carry", {31'd0, co1}, {31'd0, (raw >= 10)});
          chk("R2 digit value", {28'd0, s1}, 32'(raw % 10));
        end
  endtask

  task automatic t_ripple;  // R5
    apply4(999, 1, 1'b0, "R5 ripple three");
    apply4(9999, 0, 1'b1, "R5 ripple all via cin");
    apply4(4545, 5454, 1'b1, "R5 nines chain");
    apply4(9990, 9, 1'b1, "R5 ripple from digit0");
  endtask

  task automatic t_top_carry;  // R6
    apply4(9999, 9999, 1'b1, "R6 max sum");
    apply4(5000, 5000, 1'b0, "R6 top carry only");
    apply4(4999, 5000, 1'b0, "R6 no top carry");
  endtask

  task automatic t_carry_in;  // R7
    apply4(0, 0, 1'b1, "R7 cin alone");
    apply4(8, 0, 1'b1, "R7 cin to nine");
    apply4(9, 0, 1'b1, "R7 cin wraps digit0");
  endtask

  task automatic t_sweep;  // R3 scattered operand pairs
    for (int k = 0; k < 300; k++) begin
      apply4((k * 7919 + 13) % 10000, (k * 104729 + k * k) % 10000, k[0], "R3 sweep");
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected=<50000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a4 = '0; b4 = '0; ci4 = 1'b0;
    a1 = '0; b1 = '0; ci1 = 1'b0;
    t_idle_zero();
    t_positions();
    t_single_digit_all();
    t_ripple();
    t_top_carry();
    t_carry_in();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule